// File: doc/BRIEF.md
# Serial receive output port

This block drives a synchronous serial output carrying received baseband samples. In the normal mode every accepted I/Q sample pair leaves as two 16-bit words, I first and then Q. The block generates its own serial clock from the master clock. A configuration input selects the output rate. At 8x the symbol rate the serial clock is the master clock divided by 2. At 4x the serial clock is the master clock divided by 4, and every other incoming sample pair is dropped.

A mode input turns the same port over to command readback. Each request then leaves as a single 16-bit word: a zero in the top bit, the 7-bit register address below it, and the 8-bit read data in the low byte. A word strobe marks the first bit of every word, and a flag tells I words from Q words. A one-entry buffer absorbs an arrival while a word is still shifting. A second arrival while that buffer is full raises a sticky overrun flag.

Top module: `rxs_out_port`

## Requirements
- R1: After reset, sclk_o, sdata_o, wstrb_o, word_q_o and overrun_o are all 0, and bit order defaults to MSB first.
- R2: With rate_4x_i = 0 and rx_en_i = 1, sclk_o has a period of 2 master clocks: high for 1 and low for 1.
- R3: With rate_4x_i = 1, sclk_o has a period of 4 master clocks: high for 2 and low for 2. The rate is taken only while rx_en_i is 0.
- R4: When rb_mode_i = 0, each kept sample pair is sent as a 16-bit I word with word_q_o = 0, followed at once by a 16-bit Q word with word_q_o = 1. Both words are sent MSB first when lsb_first_i = 0.
- R5: With lsb_first_i = 1, every word is sent LSB first.
- R6: sdata_o, wstrb_o and word_q_o change only on a falling edge of sclk_o, so each bit is stable across the rising edge.
- R7: In 4x mode, after enable the first sample pair is kept, the second is discarded, the third is kept, and so on.
- R8: When rb_mode_i = 1, each rb_valid_i pulse sends one word {1'b0, rb_addr_i[6:0], rb_data_i[7:0]} with word_q_o = 0, and smp_valid_i is ignored.
- R9: When rb_mode_i = 0, rb_valid_i is ignored.
- R10: wstrb_o is high for exactly one serial clock period, aligned with the first bit of each word.
- R11: An arrival while the one-entry buffer is full and not being emptied is dropped and sets overrun_o. overrun_o stays set until rx_en_i goes low.
- R12: While rx_en_i is 0, sclk_o stays low and no words are sent. Buffered and partly sent data is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Reception enable |
| rate_4x_i | input | 1 | 1: 4x symbol rate (divide by 4, drop alternate pairs); 0: 8x |
| lsb_first_i | input | 1 | 1: send LSB first |
| rb_mode_i | input | 1 | 1: port carries readback words instead of samples |
| smp_valid_i | input | 1 | Sample pair valid, one cycle |
| smp_i_i | input | 16 | I sample |
| smp_q_i | input | 16 | Q sample |
| rb_valid_i | input | 1 | Readback request, one cycle |
| rb_addr_i | input | 7 | Readback register address |
| rb_data_i | input | 8 | Readback data |
| sclk_o | output | 1 | Serial clock; idles low |
| sdata_o | output | 1 | Serial data |
| wstrb_o | output | 1 | First-bit strobe of each word |
| word_q_o | output | 1 | 1 while a Q word is being sent |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
A divider counter that has slipped shows up within one serial period, as a wrong high or low time or as sclk_o toggling while disabled. A wrong bit counter or a wrong pending-Q state shows up at the next word boundary: the strobe appears in the middle of a word, words come out 15 or 17 bits long, or the Q word is missing or repeated. A wrong decimation phase or a wrong buffer-full state is caught one sample pair later, as a kept pair that goes missing, a dropped pair that comes out, or an overrun flag that is wrong.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  parameter int unsigned RXS_WORD_W = 16;

  typedef struct packed {
    logic                  pair;  // 1: I/Q pair, 0: single readback word
    logic [RXS_WORD_W-1:0] w0;
    logic [RXS_WORD_W-1:0] w1;
  } rxs_item_t;
endpackage

// File: rtl/rxs_clkdiv.sv
module rxs_clkdiv #(
  parameter int unsigned FAST_DIV = 2,
  parameter int unsigned SLOW_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic slow_i,
  output logic sclk_o,
  output logic tick_o,
  output logic slow_o
);
  localparam int unsigned CNT_W = $clog2(SLOW_DIV);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_DIV - 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_DIV - 1);
  localparam logic [CNT_W-1:0] FAST_HALF = CNT_W'(FAST_DIV / 2);
  localparam logic [CNT_W-1:0] SLOW_HALF = CNT_W'(SLOW_DIV / 2);

  logic [CNT_W-1:0] cnt_q, last, half;
  logic             slow_q;

  assign last   = slow_q ? SLOW_LAST : FAST_LAST;
  assign half   = slow_q ? SLOW_HALF : FAST_HALF;
  assign tick_o = en_i && (cnt_q == last);
  assign sclk_o = (cnt_q >= half);
  assign slow_o = slow_q;

  // rate is latched only while disabled so sclk never glitches mid-stream
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      slow_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      slow_q <= slow_i;
    end else if (tick_o) begin
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_FAST_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !slow_q && !$past(slow_q)) |-> (sclk_o != $past(sclk_o)))
    else $error("fast sclk did not toggle"); // R2

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !sclk_o)
    else $error("sclk high while disabled"); // R12
endmodule

// File: rtl/rxs_ingress.sv
module rxs_ingress
  import rxs_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned RDAT_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  slow_i,
  input  logic                  rb_mode_i,
  input  logic                  smp_valid_i,
  input  logic [RXS_WORD_W-1:0] smp_i_i,
  input  logic [RXS_WORD_W-1:0] smp_q_i,
  input  logic                  rb_valid_i,
  input  logic [ADDR_W-1:0]     rb_addr_i,
  input  logic [RDAT_W-1:0]     rb_data_i,
  input  logic                  pop_i,
  output logic                  full_o,
  output rxs_item_t             item_o,
  output logic                  overrun_o
);
  localparam int unsigned PAD_W = RXS_WORD_W - ADDR_W - RDAT_W;

  logic      keep_ph_q, keep, push, full_q, overrun_q;
  rxs_item_t item_q, new_item;

  // in 4x mode keep phase 0, drop phase 1
  assign keep = !slow_i || !keep_ph_q;
  assign push = en_i && (rb_mode_i ? rb_valid_i : (smp_valid_i && keep));

  always_comb begin
    if (rb_mode_i) begin
      new_item.pair = 1'b0;
      new_item.w0   = {{PAD_W{1'b0}}, rb_addr_i, rb_data_i};
      new_item.w1   = '0;
    end else begin
      new_item.pair = 1'b1;
      new_item.w0   = smp_i_i;
      new_item.w1   = smp_q_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keep_ph_q <= 1'b0;
      full_q    <= 1'b0;
      overrun_q <= 1'b0;
      item_q    <= '0;
    end else if (!en_i) begin
      keep_ph_q <= 1'b0;
      full_q    <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      if (!rb_mode_i && smp_valid_i && slow_i) keep_ph_q <= !keep_ph_q;
      if (push && (!full_q || pop_i)) begin
        full_q <= 1'b1;
        item_q <= new_item;
      end else if (pop_i) begin
        full_q <= 1'b0;
      end
      if (push && full_q && !pop_i) overrun_q <= 1'b1;
    end
  end

  assign full_o    = full_q;
  assign item_o    = item_q;
  assign overrun_o = overrun_q;

  AST_OVR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && full_q && !pop_i) |=> (overrun_q && full_q && $stable(item_q)))
    else $error("overrun not flagged or buffer overwritten"); // R11

  AST_POP_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> full_q)
    else $error("pop from empty buffer"); // R4
endmodule

// File: rtl/rxs_shifter.sv
module rxs_shifter
  import rxs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      tick_i,
  input  logic      lsb_first_i,
  input  logic      full_i,
  input  rxs_item_t item_i,
  output logic      pop_o,
  output logic      sdata_o,
  output logic      wstrb_o,
  output logic      word_q_o
);
  localparam int unsigned WORD_W = RXS_WORD_W;
  localparam int unsigned BIT_W  = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q, q_word_q;
  logic [BIT_W-1:0]  bit_q;
  logic              busy_q, q_pend_q, cur_q_q, need_new;

  function automatic logic [WORD_W-1:0] order(input logic [WORD_W-1:0] w, input logic lsb);
    logic [WORD_W-1:0] r;
    for (int k = 0; k < WORD_W; k++) r[k] = w[WORD_W-1-k];
    return lsb ? r : w;
  endfunction

  assign need_new = !busy_q || (bit_q == LAST_BIT);
  assign pop_o    = tick_i && need_new && !q_pend_q && full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      q_word_q <= '0;
      bit_q    <= '0;
      busy_q   <= 1'b0;
      q_pend_q <= 1'b0;
      cur_q_q  <= 1'b0;
    end else if (!en_i) begin
      sh_q     <= '0;
      bit_q    <= '0;
      busy_q   <= 1'b0;
      q_pend_q <= 1'b0;
      cur_q_q  <= 1'b0;
    end else if (tick_i) begin
      if (need_new) begin
        bit_q <= '0;
        if (q_pend_q) begin
          sh_q     <= order(q_word_q, lsb_first_i);
          cur_q_q  <= 1'b1;
          q_pend_q <= 1'b0;
          busy_q   <= 1'b1;
        end else if (full_i) begin
          sh_q     <= order(item_i.w0, lsb_first_i);
          q_word_q <= item_i.w1;
          q_pend_q <= item_i.pair;
          cur_q_q  <= 1'b0;
          busy_q   <= 1'b1;
        end else begin
          sh_q    <= '0;
          cur_q_q <= 1'b0;
          busy_q  <= 1'b0;
        end
      end else begin
        sh_q  <= sh_q << 1;
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign sdata_o  = busy_q & sh_q[WORD_W-1];
  assign wstrb_o  = busy_q && (bit_q == '0);
  assign word_q_o = busy_q && cur_q_q;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (!wstrb_o && !sdata_o && !word_q_o))
    else $error("output activity while disabled"); // R12

  AST_Q_AFTER_I: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && q_pend_q && busy_q && bit_q == LAST_BIT) |=> (wstrb_o && word_q_o))
    else $error("Q word did not follow I word"); // R4
endmodule

// File: rtl/rxs_out_port.sv
module rxs_out_port
  import rxs_pkg::*;
#(
  parameter int unsigned FAST_DIV = 2,
  parameter int unsigned SLOW_DIV = 4,
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned RDAT_W   = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rx_en_i,
  input  logic                  rate_4x_i,
  input  logic                  lsb_first_i,
  input  logic                  rb_mode_i,
  input  logic                  smp_valid_i,
  input  logic [RXS_WORD_W-1:0] smp_i_i,
  input  logic [RXS_WORD_W-1:0] smp_q_i,
  input  logic                  rb_valid_i,
  input  logic [ADDR_W-1:0]     rb_addr_i,
  input  logic [RDAT_W-1:0]     rb_data_i,
  output logic                  sclk_o,
  output logic                  sdata_o,
  output logic                  wstrb_o,
  output logic                  word_q_o,
  output logic                  overrun_o
);
  logic      tick, slow, pop, full;
  rxs_item_t item;

  rxs_clkdiv #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rx_en_i),
    .slow_i (rate_4x_i),
    .sclk_o (sclk_o),
    .tick_o (tick),
    .slow_o (slow)
  );

  rxs_ingress #(.ADDR_W(ADDR_W), .RDAT_W(RDAT_W)) u_ing (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (rx_en_i),
    .slow_i      (slow),
    .rb_mode_i   (rb_mode_i),
    .smp_valid_i (smp_valid_i),
    .smp_i_i     (smp_i_i),
    .smp_q_i     (smp_q_i),
    .rb_valid_i  (rb_valid_i),
    .rb_addr_i   (rb_addr_i),
    .rb_data_i   (rb_data_i),
    .pop_i       (pop),
    .full_o      (full),
    .item_o      (item),
    .overrun_o   (overrun_o)
  );

  rxs_shifter u_sh (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (rx_en_i),
    .tick_i      (tick),
    .lsb_first_i (lsb_first_i),
    .full_i      (full),
    .item_i      (item),
    .pop_o       (pop),
    .sdata_o     (sdata_o),
    .wstrb_o     (wstrb_o),
    .word_q_o    (word_q_o)
  );

  AST_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rx_en_i) && !$fell(sclk_o)) |-> ($stable(sdata_o) && $stable(wstrb_o) && $stable(word_q_o)))
    else $error("serial data changed away from sclk fall"); // R6
endmodule

// File: tb/sim_rxs_out_port.sv
module sim_rxs_out_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, rate_4x = 1'b0, lsb_first = 1'b0, rb_mode = 1'b0;
  logic smp_valid = 1'b0, rb_valid = 1'b0;
  logic [15:0] smp_i = '0, smp_q = '0;
  logic [6:0] rb_addr = '0;
  logic [7:0] rb_data = '0;
  logic sclk, sdata, wstrb, word_q, overrun;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxs_out_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .rate_4x_i(rate_4x),
    .lsb_first_i(lsb_first), .rb_mode_i(rb_mode), .smp_valid_i(smp_valid),
    .smp_i_i(smp_i), .smp_q_i(smp_q), .rb_valid_i(rb_valid), .rb_addr_i(rb_addr),
    .rb_data_i(rb_data), .sclk_o(sclk), .sdata_o(sdata), .wstrb_o(wstrb),
    .word_q_o(word_q), .overrun_o(overrun)
  );

  // serial receiver model, sampled away from the active edge
  logic [15:0] cap_w [64];
  logic        cap_q [64];
  int cap_n = 0, rises = 0, period = 0, last_rise = 0, cyc = 0;
  int strobe_err = 0, r6_err = 0, bits = 0;
  logic [15:0] cur = '0;
  logic curq = 1'b0, prev_sclk = 1'b0, prev_sdata = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!rx_en) bits = 0;
    if (prev_sclk && sclk && (sdata != prev_sdata)) r6_err++;
    if (sclk && !prev_sclk) begin
      rises++;
      period = cyc - last_rise;
      last_rise = cyc;
      if (wstrb) begin
        if (bits != 0) strobe_err++;
        cur = {15'b0, sdata};
        bits = 1;
        curq = word_q;
      end else if (bits > 0) begin
        cur = {cur[14:0], sdata};
        bits++;
      end
      if (bits == 16) begin
        if (cap_n < 64) begin
          cap_w[cap_n] = cur;
          cap_q[cap_n] = curq;
        end
        cap_n++;
        bits = 0;
      end
    end
    prev_sclk = sclk;
    prev_sdata = sdata;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (R1..all): actual %0d cycles expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [15:0] rev16(input logic [15:0] w);
    logic [15:0] r;
    for (int k = 0; k < 16; k++) r[k] = w[15-k];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int base = 0;

  task automatic restart(input logic slow, input logic lsb, input logic rb);
    @(negedge clk);
    rx_en = 1'b0;
    rate_4x = slow; lsb_first = lsb; rb_mode = rb;
    repeat (3) @(negedge clk);
    rx_en = 1'b1;
    base = cap_n;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_pair(input logic [15:0] i, input logic [15:0] q);
    @(negedge clk);
    smp_valid = 1'b1; smp_i = i; smp_q = q;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic send_rb(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    rb_valid = 1'b1; rb_addr = a; rb_data = d;
    @(negedge clk);
    rb_valid = 1'b0;
  endtask

  task automatic wait_words(input int n);
    int k = 0;
    while ((cap_n - base) < n && k < 2000) begin
      @(negedge clk);
      k++;
    end
    repeat (40) @(negedge clk);
  endtask

  // {slow, lsb, rb, w0, w1}; for rb entries w0[14:8]=addr, w0[7:0]=data
  localparam logic [34:0] VECS [6] = '{
    {1'b0, 1'b0, 1'b0, 16'hA5C3, 16'h1E0F},
    {1'b0, 1'b1, 1'b0, 16'h8001, 16'h7FFE},
    {1'b1, 1'b0, 1'b0, 16'h1234, 16'hABCD},
    {1'b1, 1'b1, 1'b0, 16'hF00D, 16'h0BEE},
    {1'b0, 1'b0, 1'b1, 16'hFF81, 16'h0000},
    {1'b1, 1'b1, 1'b1, 16'h053C, 16'h0000}
  };

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(sclk == 0 && sdata == 0 && wstrb == 0 && word_q == 0, "R1", "outputs in reset",
          {sclk, sdata, wstrb, word_q}, 0);
    check(overrun == 0, "R1", "overrun in reset", overrun, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(rises == 0 && sclk == 0, "R12", "sclk idle while disabled", rises, 0);

    for (int v = 0; v < 6; v++) begin
      logic [34:0] e;
      logic [15:0] w0x, want;
      int nexp;
      string req;
      e = VECS[v];
      restart(e[34], e[33], e[32]);
      if (e[32]) begin
        send_rb(e[30:24], e[23:16]);
        nexp = 1;
        w0x = {1'b0, e[30:16]};
      end else begin
        send_pair(e[31:16], e[15:0]);
        if (e[34]) send_pair(16'hDEAD, 16'hBEEF); // R7: second pair dropped
        nexp = 2;
        w0x = e[31:16];
      end
      wait_words(nexp);
      req = e[32] ? "R8" : (e[34] ? "R7" : "R4");
      check((cap_n - base) == nexp, req, "word count", cap_n - base, nexp);
      for (int k = 0; k < nexp; k++) begin
        want = (k == 0) ? w0x : e[15:0];
        if (e[33]) want = rev16(want);
        check(cap_w[base+k] == want, e[33] ? "R5" : (e[32] ? "R8" : "R4"), "word value",
              cap_w[base+k], want);
        check(cap_q[base+k] == (k == 1), "R4", "I/Q flag", cap_q[base+k], (k == 1));
      end
      if (e[34]) check(period == 4, "R3", "4x sclk period", period, 4);
      else       check(period == 2, "R2", "8x sclk period", period, 2);
    end

    // R9: readback ignored outside readback mode
    restart(1'b0, 1'b0, 1'b0);
    send_rb(7'h11, 8'h22);
    repeat (80) @(negedge clk);
    check((cap_n - base) == 0, "R9", "words from rb_valid", cap_n - base, 0);

    // R8: samples ignored in readback mode
    restart(1'b0, 1'b0, 1'b1);
    send_pair(16'h1111, 16'h2222);
    repeat (80) @(negedge clk);
    check((cap_n - base) == 0, "R8", "words from smp_valid", cap_n - base, 0);

    // R7: keep, drop, keep across spaced arrivals
    restart(1'b1, 1'b0, 1'b0);
    send_pair(16'h1111, 16'h2222);
    wait_words(2);
    send_pair(16'h3333, 16'h4444);
    repeat (200) @(negedge clk);
    send_pair(16'h5555, 16'h6666);
    wait_words(4);
    check((cap_n - base) == 4, "R7", "decimated word count", cap_n - base, 4);
    check(cap_w[base+2] == 16'h5555, "R7", "third pair I", cap_w[base+2], 16'h5555);
    check(cap_w[base+3] == 16'h6666, "R7", "third pair Q", cap_w[base+3], 16'h6666);

    // R11: buffer full, third arrival dropped
    restart(1'b0, 1'b0, 1'b0);
    send_pair(16'hAAAA, 16'h5555);
    repeat (10) @(negedge clk);
    check(overrun == 0, "R11", "no overrun yet", overrun, 0);
    send_pair(16'h0F0F, 16'hF0F0);
    repeat (2) @(negedge clk);
    send_pair(16'hFFFF, 16'h0000);
    check(overrun == 1, "R11", "overrun set", overrun, 1);
    wait_words(4);
    check((cap_n - base) == 4, "R11", "word count after overrun", cap_n - base, 4);
    check(cap_w[base+2] == 16'h0F0F, "R11", "buffered I", cap_w[base+2], 16'h0F0F);
    check(cap_w[base+3] == 16'hF0F0, "R11", "buffered Q", cap_w[base+3], 16'hF0F0);
    check(overrun == 1, "R11", "overrun sticky", overrun, 1);
    @(negedge clk); rx_en = 1'b0;
    repeat (2) @(negedge clk);
    check(overrun == 0, "R11", "overrun cleared by disable", overrun, 0);

    // R12: disable mid-word discards the rest
    restart(1'b0, 1'b0, 1'b0);
    send_pair(16'hC3C3, 16'h3C3C);
    send_pair(16'h7777, 16'h8888);
    repeat (10) @(negedge clk);
    rx_en = 1'b0;
    @(negedge clk);
    begin
      int rr;
      rr = rises;
      repeat (20) @(negedge clk);
      check(rises == rr && sclk == 0, "R12", "sclk stopped", rises - rr, 0);
      check(wstrb == 0 && sdata == 0, "R12", "data idle", {wstrb, sdata}, 0);
    end
    rx_en = 1'b1;
    base = cap_n;
    repeat (150) @(negedge clk);
    check((cap_n - base) == 0, "R12", "stale words after re-enable", cap_n - base, 0);

    check(strobe_err == 0, "R10", "strobe not on first bit", strobe_err, 0);
    check(r6_err == 0, "R6", "data moved while sclk high", r6_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule